// File: doc/BRIEF.md
# Serial ADC Host Reader Controller

This block is the host side of a three-wire serial link to a successive-approximation converter. The host drives an active-low select and a data clock, and it receives one serial data line. When a start request is accepted, the block pulls the select low and derives the data clock from the system clock through a programmable divider. It samples the data line on each rising data-clock edge. The first five clock periods belong to the converter's sampling window and are ignored. The sixth captured bit is a null bit that must read low. After it come up to sixteen result bits, most significant first.

The requested bit count runs from 1 to 16. The block raises the select on the falling clock edge that follows the last wanted bit. A short frame therefore costs only as many clocks as it needs. The result is presented left-justified, and the bits that were not requested read as zero. In verify mode the block always reads the full word. It then keeps the clock running through the fifteen bits that the converter repeats in reverse order after the last data bit, and it compares each of them with the word already captured. After every frame the select stays high for at least one full data-clock period before the next start can be accepted.

The start side is a valid/ready handshake. The requester holds `start_valid` and the configuration stable until `start_ready` is seen high at a clock edge. The result side has no back-pressure: `res_valid` is a one-cycle strobe, and the consumer must take `res_data` and `res_verify_err` in that cycle. `res_data` keeps its value until the next good frame ends.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, `start_ready` is 1, and `res_valid`, `res_null_err` and `res_verify_err` are 0. `adc_sclk` is 0 in every cycle in which `adc_cs_n` is 1.
- R2: A start is taken only in a cycle where `start_valid` and `start_ready` are both 1. `cfg_div`, `cfg_nbits` and `cfg_verify` are captured in that cycle, and changing them later in the frame has no effect on that frame.
- R3: Each data-clock half period lasts `cfg_div`+1 system clocks. `adc_sclk` is 0 when `adc_cs_n` falls. The first rising edge comes one half period after the select falls.
- R4: Numbering the rising data-clock edges of a frame from 1, edges 1 to 5 are ignored and edge 6 samples the null bit. Edges 7 to 22 sample result bits 15 down to 0.
- R5: A `cfg_nbits` value of m requests n = m+1 bits. Without verify mode a frame has exactly 6+n rising edges, and `adc_cs_n` rises on the falling edge after the last of them.
- R6: At the end of a good frame, `res_valid` pulses for exactly one cycle, in the same cycle that `adc_cs_n` reads high again. `res_data` then holds the n sampled bits in positions 15 down to 16-n, and its lower bits are 0.
- R7: If the null bit samples 1, the frame ends on the next falling edge, after 6 rising edges. `res_null_err` pulses for one cycle in place of `res_valid`, and `res_data` keeps its old value.
- R8: With `cfg_verify` = 1 the bit count is forced to 16 and the frame runs to rising edge 37. Edge 22+j samples the repeat of result bit j, for j from 1 to 15. `res_verify_err` is 1 alongside `res_valid` when any repeat bit differs from the captured bit, and it is 0 otherwise.
- R9: Between the rise of `adc_cs_n` and its next fall there are at least two half periods of the previous frame.
- R10: `start_ready` is 1 only while the block is idle with `adc_cs_n` high. There is no ready on the result side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Block idle, start may be taken |
| cfg_div | input | DIV_W | Half-period length minus one, in system clocks |
| cfg_nbits | input | $clog2(DATA_W) | Requested bit count minus one |
| cfg_verify | input | 1 | Read the reversed repeat and compare |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Data clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle strobe for a good result |
| res_data | output | DATA_W | Left-justified result |
| res_null_err | output | 1 | One-cycle strobe when the null bit read high |
| res_verify_err | output | 1 | Repeat mismatch, qualified by res_valid |

## Verification
The bench models the converter from the select and clock pins. It aims at the extreme bit counts 1 and 16, at the fastest divider setting where a half period is a single system clock, at a null bit that reads high, and at mismatches injected into the first and the last repeat bit. If the edge count were off by one, the wrong bit would land in the MSB, or the frame would show one rising edge too many or too few. A lost verify comparison would leave `res_verify_err` low on a corrupted repeat. It also measures half periods, the time from the select falling to the first rising edge, and the select-high gap, and it changes the configuration in the middle of each frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GUARD} rd_state_e;
  localparam int SAMPLE_CLKS = 5;
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= div_val);
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EDGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              sdo,
  output logic [DATA_W-1:0] word,
  output logic              null_bad,
  output logic              mism
);
  localparam int NULL_EDGE   = SAMPLE_CLKS + 1;
  localparam int LAST_FULL   = NULL_EDGE + DATA_W;
  localparam int LAST_VERIFY = LAST_FULL + DATA_W - 1;
  localparam int NB_W        = $clog2(DATA_W);

  logic            in_data, in_rep;
  logic [NB_W-1:0] dpos, rpos;

  always_comb begin
    in_data = (edge_idx > EDGE_W'(NULL_EDGE)) && (edge_idx <= EDGE_W'(LAST_FULL));
    in_rep  = (edge_idx > EDGE_W'(LAST_FULL)) && (edge_idx <= EDGE_W'(LAST_VERIFY));
    dpos    = NB_W'(EDGE_W'(LAST_FULL) - edge_idx);
    rpos    = NB_W'(edge_idx - EDGE_W'(LAST_FULL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      null_bad <= 1'b0;
      mism     <= 1'b0;
    end else if (clear) begin
      word     <= '0;
      null_bad <= 1'b0;
      mism     <= 1'b0;
    end else if (cap) begin
      if (edge_idx == EDGE_W'(NULL_EDGE)) null_bad <= sdo;
      else if (in_data)                   word[dpos] <= sdo;
      else if (in_rep && (sdo != word[rpos])) mism <= 1'b1;
    end
  end

  a_r4_sticky_mism: assert property (@(posedge clk) disable iff (!rst_n)
    (mism && !clear) |=> mism);
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int NB_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [NB_W-1:0]   cfg_nbits,
  input  logic              cfg_verify,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_sdo,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_null_err,
  output logic              res_verify_err
);
  localparam int NULL_EDGE   = SAMPLE_CLKS + 1;
  localparam int LAST_FULL   = NULL_EDGE + DATA_W;
  localparam int LAST_VERIFY = LAST_FULL + DATA_W - 1;
  localparam int EDGE_W      = $clog2(LAST_VERIFY + 1);

  rd_state_e         state_q;
  logic              sclk_q, cs_n_q, guard_q, vfy_q;
  logic [EDGE_W-1:0] rise_q, last_q, edge_next;
  logic [DIV_W-1:0]  div_q;
  logic              tick, accept, rise_stb, fall_stb, end_frame;
  logic [DATA_W-1:0] word;
  logic              null_bad, mism;

  assign start_ready = (state_q == ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign rise_stb    = (state_q == ST_RUN) && tick && !sclk_q;
  assign fall_stb    = (state_q == ST_RUN) && tick && sclk_q;
  assign edge_next   = rise_q + 1'b1;
  assign end_frame   = fall_stb && ((rise_q == last_q) || null_bad);
  assign adc_cs_n    = cs_n_q;
  assign adc_sclk    = sclk_q;

  adc_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE),
    .div_val(div_q), .tick(tick));

  adc_rd_shifter #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cap(rise_stb),
    .edge_idx(edge_next), .sdo(adc_sdo), .word(word),
    .null_bad(null_bad), .mism(mism));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      guard_q <= 1'b0;
      vfy_q   <= 1'b0;
      rise_q  <= '0;
      last_q  <= '0;
      div_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          cs_n_q  <= 1'b0;
          rise_q  <= '0;
          div_q   <= cfg_div;
          vfy_q   <= cfg_verify;
          last_q  <= cfg_verify ? EDGE_W'(LAST_VERIFY)
                                : EDGE_W'(NULL_EDGE + 1) + EDGE_W'(cfg_nbits);
        end
        ST_RUN: begin
          if (rise_stb) begin
            sclk_q <= 1'b1;
            rise_q <= edge_next;
          end else if (fall_stb) begin
            sclk_q <= 1'b0;
            if (end_frame) begin
              cs_n_q  <= 1'b1;
              guard_q <= 1'b0;
              state_q <= ST_GUARD;
            end
          end
        end
        ST_GUARD: if (tick) begin
          if (guard_q) state_q <= ST_IDLE;
          guard_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_null_err   <= 1'b0;
      res_verify_err <= 1'b0;
      res_data       <= '0;
    end else begin
      res_valid      <= end_frame && !null_bad;
      res_null_err   <= end_frame && null_bad;
      res_verify_err <= end_frame && !null_bad && vfy_q && mism;
      if (end_frame && !null_bad) res_data <= word;
    end
  end

  a_r1_clock_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r7_exclusive_status: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_null_err));
  a_r5_end_with_select_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || res_null_err) |-> $rose(adc_cs_n));
  a_r10_ready_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> adc_cs_n);
  a_r8_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q <= EDGE_W'(LAST_VERIFY));
  a_r8_flag_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    res_verify_err |-> res_valid);
endmodule

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;
  localparam int NB_W   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0, cfg_verify = 1'b0, adc_sdo = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [NB_W-1:0]  cfg_nbits = '0;
  logic start_ready, adc_cs_n, adc_sclk, res_valid, res_null_err, res_verify_err;
  logic [DATA_W-1:0] res_data;

  int total = 0, bad = 0, cycles = 0;

  adc_serial_reader #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_adc_serial_reader (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .cfg_div(cfg_div), .cfg_nbits(cfg_nbits), .cfg_verify(cfg_verify),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
    .res_valid(res_valid), .res_data(res_data), .res_null_err(res_null_err),
    .res_verify_err(res_verify_err));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model
  logic [DATA_W-1:0] m_word = '0;
  bit m_null = 0;
  int m_flip = 0, m_falls = 0;
  always @(negedge adc_cs_n) begin m_falls = 0; adc_sdo = 1'b0; end
  always @(negedge adc_sclk) if (!adc_cs_n) begin
    m_falls++;
    if (m_falls == 5) adc_sdo = m_null;
    else if (m_falls >= 6 && m_falls <= 21) adc_sdo = m_word[21-m_falls];
    else if (m_falls >= 22 && m_falls <= 36) adc_sdo = m_word[m_falls-21] ^ (m_falls == m_flip);
    else adc_sdo = 1'b0;
  end

  // pin timing monitor
  int rises = 0, cur_h = 1, prev_h = 1;
  bit first_rise = 0, have_prev = 0;
  time t_fall = 0, t_rose = 0, t_last = 0;
  always @(negedge adc_cs_n) begin
    t_fall = $time; rises = 0; first_rise = 1;
    chk(adc_sclk == 1'b0, "R3 clock low at select fall", adc_sclk, 0);
    if (have_prev)
      chk((t_fall - t_rose) >= time'(2*prev_h*CLK_P), "R9 select high gap",
          t_fall - t_rose, 2*prev_h*CLK_P);
  end
  always @(posedge adc_sclk) if (!adc_cs_n) begin
    rises++;
    if (first_rise)
      chk(($time - t_fall) == time'(cur_h*CLK_P), "R3 first rise delay", $time - t_fall, cur_h*CLK_P);
    else
      chk(($time - t_last) == time'(2*cur_h*CLK_P), "R3 clock period", $time - t_last, 2*cur_h*CLK_P);
    first_rise = 0; t_last = $time;
  end
  always @(posedge adc_cs_n) begin t_rose = $time; have_prev = 1; prev_h = cur_h; end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] exp_word(logic [DATA_W-1:0] w, int n);
    logic [DATA_W-1:0] msk = ~(({DATA_W{1'b1}}) >> n);
    return w & msk;
  endfunction

  task automatic frame(input int dv, input int nb, input bit vfy,
                       input logic [DATA_W-1:0] w, input bit nul, input int flip);
    int n = vfy ? 16 : nb + 1;
    int er = nul ? 6 : (vfy ? 37 : 6 + n);
    logic [DATA_W-1:0] old = res_data;
    int guard = 0;
    m_word = w; m_null = nul; m_flip = flip; cur_h = dv + 1;
    @(negedge clk);
    start_valid = 1'b1; cfg_div = DIV_W'(dv); cfg_nbits = NB_W'(nb); cfg_verify = vfy;
    while (!start_ready) @(negedge clk);
    @(negedge clk);
    start_valid = 1'b0; cfg_div = ~cfg_div; cfg_nbits = ~cfg_nbits; cfg_verify = ~vfy; // R2 ignored
    while (!(res_valid || res_null_err) && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R6 frame completes", guard, 0);
    chk(adc_cs_n == 1'b1, "R5 select high at end", adc_cs_n, 1);
    chk(rises == er, nul ? "R7 edges on null error" : (vfy ? "R8 edges in verify" : "R5 edge count"), rises, er);
    if (nul) begin
      chk(res_null_err && !res_valid, "R7 null error strobe", {res_null_err, res_valid}, 2'b10);
      chk(res_data == old, "R7 result kept", res_data, old);
    end else begin
      chk(res_valid && !res_null_err, "R6 valid strobe", {res_valid, res_null_err}, 2'b10);
      chk(res_data == exp_word(w, n), "R4 R6 result", res_data, exp_word(w, n));
      chk(res_verify_err == (vfy && flip != 0), "R8 verify flag", res_verify_err, (vfy && flip != 0));
    end
    @(negedge clk);
    chk(!res_valid && !res_null_err, "R6 one cycle pulse", {res_valid, res_null_err}, 0);
    cfg_verify = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R1 reset pins", {adc_cs_n, adc_sclk}, 2'b10);
    chk(start_ready == 1'b1, "R1 R10 ready in reset", start_ready, 1);
    chk(!res_valid && !res_null_err && !res_verify_err, "R1 status low", res_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(adc_cs_n == 1'b1 && start_ready, "R1 idle after reset", {adc_cs_n, start_ready}, 2'b11);
    chk(!(adc_cs_n && adc_sclk), "R1 clock low idle", adc_sclk, 0);
    frame(0, 15, 0, 16'hA5C3, 0, 0);
    frame(0, 0, 0, 16'h8000, 0, 0);
    frame(2, 0, 0, 16'h7FFF, 0, 0);
    frame(1, 15, 0, 16'hFFFF, 0, 0);
    frame(0, 7, 0, 16'h0000, 0, 0);
    frame(1, 9, 0, 16'h1234, 1, 0);
    frame(0, 15, 1, 16'hBEEF, 0, 0);
    frame(0, 15, 1, 16'hBEEF, 0, 22);
    frame(2, 3, 1, 16'h0F0F, 0, 36);
    frame(0, 2, 1, 16'h5555, 1, 0);
    for (int i = 0; i < 50; i++) begin
      int dv = int'($urandom_range(0, 3));
      int nb = int'($urandom_range(0, 15));
      bit vf = ($urandom_range(0, 3) == 0);
      bit nl = ($urandom_range(0, 7) == 0);
      int fl = (vf && $urandom_range(0, 1) == 1) ? int'($urandom_range(22, 36)) : 0;
      frame(dv, nb, vf, DATA_W'($urandom), nl, fl);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule